// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Arbiter

This block decides which event the processor services next. Sixteen peripheral request lines each carry a programmable priority level and a routing bit. The routing bit sends a granted request either to a CPU interrupt, where the processor priority is raised, or to a single-transfer data-move engine, which needs no context save. Four hardware trap inputs sit above all of these. A trap always wins over interrupts. It can be preempted only by a trap of higher rank. Every trap leaves a sticky bit in a flag register that software reads and clears.

Requests are latched and re-arbitrated on every clock. When a request wins and is eligible, the block issues a one-cycle acknowledge that carries a service kind and a vector index. In the same clock edge it clears the latched request and, for CPU interrupts, raises the processor level. A return pulse ends the innermost service: the innermost trap if one is active, otherwise the innermost CPU interrupt level. A consumer ready input holds every grant back while the consumer is busy.

Top module: `irq_trap_arbiter`

## Requirements
- R1: After reset the acknowledge is idle (valid 0, kind 0, vector 0), the CPU level is 0, the trap flags are all 0, all source levels are 0 and all routing bits select the CPU interrupt.
- R2: A high on a request line latches that source as pending at the clock edge. A latched request is acknowledged at the earliest two edges after its pulse and is cleared at the edge that issues its acknowledge, so one pulse gives one acknowledge. A pulse on the acknowledge edge is latched again.
- R3: The winner is re-chosen every cycle among pending sources with a nonzero level. The highest level wins, and on equal levels the lower source index wins. A level-0 source is never acknowledged.
- R4: A winner whose routing bit is 1 is acknowledged with kind 2 (transfer) whatever the CPU level is, and the CPU level is left unchanged.
- R5: A winner whose routing bit is 0 is acknowledged with kind 1 (CPU interrupt) only if its level is strictly above the CPU level, and the CPU level then becomes that level. If it is not above, no acknowledge is issued that cycle.
- R6: The vector is the source index for kinds 1 and 2, and 16 plus the trap index for traps.
- R7: A return pulse with no trap in service restores the CPU level that was in force before the most recent raise. With nothing in service it has no effect.
- R8: A trap pulse sets its flag bit, and the bit holds until a clear write with that mask bit set. A trap pulse in the same cycle as a clear write leaves the bit set.
- R9: A pending trap is acknowledged with kind 3 when no trap is in service, or when its index is lower than that of the innermost trap in service (index 0 ranks highest). A return pulse ends the innermost trap service first.
- R10: While any trap is pending or in service, no kind 1 or kind 2 acknowledge is issued.
- R11: While the ready input is low, no acknowledge of any kind is issued and every pending request is kept.
- R12: A configuration write sets one source's level and routing bit, and arbitration uses the new values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 16 | Peripheral request lines, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | 4 | Source selected by the configuration write |
| cfg_level_i | input | 4 | Priority level to write |
| cfg_xfer_i | input | 1 | Routing bit to write: 1 selects the transfer service |
| trap_i | input | 4 | Hardware trap pulses, index 0 ranks highest |
| trap_clr_we_i | input | 1 | Trap flag clear strobe |
| trap_clr_mask_i | input | 4 | Trap flag bits to clear |
| reti_i | input | 1 | Return-from-service pulse |
| ack_ready_i | input | 1 | Consumer can accept an acknowledge |
| ack_valid_o | output | 1 | One-cycle acknowledge |
| ack_kind_o | output | 2 | 0 none, 1 CPU interrupt, 2 transfer, 3 trap |
| ack_vector_o | output | 5 | Vector index of the acknowledged event |
| cpu_level_o | output | 4 | Current CPU priority level |
| trap_flags_o | output | 4 | Sticky trap flag register |

## Verification
Directed sequences drive two sources of equal level in the same cycle and a later high-level arrival against an older low-level request. These separate index tie-breaking from first-come ordering. A transfer-routed source is pulsed while the CPU level is above its own, which shows the transfer path skips the level test. Nested traps, issued in the order middle, high, low, with interrupts waiting behind them, check preemption rank and the pop order of returns. A long random phase then mixes requests, reconfiguration, traps, clears, returns and stalls of the ready input against a behavioural model of stacks and queues.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_CPU  = 2'd1,
    ACK_XFER = 2'd2,
    ACK_TRAP = 2'd3
  } ack_kind_e;

  // index width that never collapses to zero bits
  function automatic int safe_clog2(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;

  // one flop per source; a new request wins over the clear of an acknowledge
  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q[g] <= 1'b0;
      else if (set_i[g])  pend_q[g] <= 1'b1;
      else if (clr_i[g])  pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R2: an acknowledged request without a fresh pulse is gone next cycle
  p_clear_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr_i & ~set_i)) == '0);

  // R2: every pulse is latched
  p_latch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (~pend_q & $past(set_i)) == '0);

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int N     = 16,
  parameter int LVL_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              pend_i,
  input  logic [N-1:0][LVL_W-1:0]   lvl_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [LVL_W-1:0]          win_lvl_o
);

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    logic [LVL_W-1:0] lvl;
  } cand_t;

  // scan from the top index down; ">=" lets a lower index take a tie
  function automatic cand_t pick_winner(input logic [N-1:0] p,
                                        input logic [N-1:0][LVL_W-1:0] l);
    cand_t best;
    best = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (p[i] && (l[i] != '0) && (!best.valid || (l[i] >= best.lvl))) begin
        best.valid = 1'b1;
        best.idx   = IDX_W'(i);
        best.lvl   = l[i];
      end
    end
    return best;
  endfunction

  cand_t win;
  assign win         = pick_winner(pend_i, lvl_i);
  assign win_valid_o = win.valid;
  assign win_idx_o   = win.idx;
  assign win_lvl_o   = win.lvl;

  // R3: the winner is pending, nonzero, and reports its own level
  p_winner_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (pend_i[win_idx_o] && (win_lvl_o != '0) && (win_lvl_o == lvl_i[win_idx_o])));

  // R3: nothing pending means no winner
  p_idle_no_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_valid_o);

endmodule

// File: rtl/irq_trap_unit.sv
module irq_trap_unit #(
  parameter int NT     = 4,
  parameter int TIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     trap_i,
  input  logic              clr_we_i,
  input  logic [NT-1:0]     clr_mask_i,
  input  logic              ready_i,
  input  logic              reti_i,
  output logic              go_o,
  output logic [TIDX_W-1:0] idx_o,
  output logic              busy_o,
  output logic              in_svc_o,
  output logic [NT-1:0]     flags_o
);

  logic [NT-1:0] pend_q, svc_q, flags_q;
  logic [NT-1:0] go_mask, pop_mask, clr_eff;
  logic [TIDX_W:0] cand, inner;

  // {found, index} of the lowest set bit, i.e. the highest-ranked trap
  function automatic logic [TIDX_W:0] lowest_set(input logic [NT-1:0] v);
    logic [TIDX_W:0] r;
    r = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, TIDX_W'(i)};
    end
    return r;
  endfunction

  function automatic logic [NT-1:0] onehot(input logic [TIDX_W-1:0] i);
    return {{(NT-1){1'b0}}, 1'b1} << i;
  endfunction

  assign cand  = lowest_set(pend_q);
  assign inner = lowest_set(svc_q);
  assign idx_o = cand[TIDX_W-1:0];

  // a trap enters when nothing is in service or it outranks the innermost one
  assign go_o = ready_i && cand[TIDX_W] &&
                (!inner[TIDX_W] || (cand[TIDX_W-1:0] < inner[TIDX_W-1:0]));

  assign go_mask  = go_o ? onehot(cand[TIDX_W-1:0]) : '0;
  assign pop_mask = (reti_i && inner[TIDX_W]) ? onehot(inner[TIDX_W-1:0]) : '0;
  assign clr_eff  = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      svc_q   <= '0;
      flags_q <= '0;
    end else begin
      pend_q  <= (pend_q & ~go_mask) | trap_i;
      svc_q   <= (svc_q & ~pop_mask) | go_mask;
      flags_q <= (flags_q & ~clr_eff) | trap_i;
    end
  end

  assign busy_o   = (pend_q != '0) || (svc_q != '0);
  assign in_svc_o = (svc_q != '0);
  assign flags_o  = flags_q;

  // R8: a flag only drops under an explicit clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (~flags_q & $past(flags_q) & ~$past(clr_eff)) == '0);

  // R8: a trap pulse always leaves its flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (~flags_q & $past(trap_i)) == '0);

  // R9: entering a trap without a return adds exactly one service level
  p_nest_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && !reti_i) |=> ($countones(svc_q) == $countones($past(svc_q)) + 1));

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_i,
  input  logic [LVL_W-1:0] raise_lvl_i,
  input  logic             reti_i,
  output logic [LVL_W-1:0] cpu_level_o
);

  localparam int NLVL = 1 << LVL_W;

  // one bit per level in service; nesting is strictly increasing, so the
  // highest set bit is the current level and a return clears exactly it
  logic [NLVL-1:0] act_q, top_oh, raise_oh;

  function automatic logic [LVL_W-1:0] top_level(input logic [NLVL-1:0] m);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (m[i]) r = LVL_W'(i);
    end
    return r;
  endfunction

  assign cpu_level_o = top_level(act_q);
  assign top_oh      = (act_q != '0) ? ({{(NLVL-1){1'b0}}, 1'b1} << cpu_level_o) : '0;
  assign raise_oh    = raise_i ? ({{(NLVL-1){1'b0}}, 1'b1} << raise_lvl_i) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q & ~(reti_i ? top_oh : '0)) | raise_oh;
  end

  // R5: a raise always goes above the level in force
  p_raise_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |-> (raise_lvl_i > cpu_level_o));

  // R5: the granted level becomes the CPU level
  p_level_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> (cpu_level_o == $past(raise_lvl_i)));

  // R7: a return with something in service lowers the level
  p_return_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !raise_i && (act_q != '0)) |=> (cpu_level_o < $past(cpu_level_o)));

endmodule

// File: rtl/irq_trap_arbiter.sv
module irq_trap_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int NUM_SRC  = 16,
  parameter  int LVL_W    = 4,
  parameter  int NUM_TRAP = 4,
  localparam int IDX_W    = safe_clog2(NUM_SRC),
  localparam int TIDX_W   = safe_clog2(NUM_TRAP),
  localparam int VEC_W    = safe_clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_req_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_src_i,
  input  logic [LVL_W-1:0]    cfg_level_i,
  input  logic                cfg_xfer_i,
  input  logic [NUM_TRAP-1:0] trap_i,
  input  logic                trap_clr_we_i,
  input  logic [NUM_TRAP-1:0] trap_clr_mask_i,
  input  logic                reti_i,
  input  logic                ack_ready_i,
  output logic                ack_valid_o,
  output logic [1:0]          ack_kind_o,
  output logic [VEC_W-1:0]    ack_vector_o,
  output logic [LVL_W-1:0]    cpu_level_o,
  output logic [NUM_TRAP-1:0] trap_flags_o
);

  // ---------------- per-source configuration ----------------
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_SRC-1:0]            xfer_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[g]  <= '0;
        xfer_q[g] <= 1'b0;
      end else if (cfg_we_i && (cfg_src_i == IDX_W'(g))) begin
        lvl_q[g]  <= cfg_level_i;
        xfer_q[g] <= cfg_xfer_i;
      end
    end
  end

  // ---------------- named internal events ----------------
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] ack_clr;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  logic               win_xfer;
  logic               trap_go, trap_busy, trap_in_svc;
  logic [TIDX_W-1:0]  trap_idx;
  logic               irq_go, cpu_go, lvl_reti;

  function automatic logic cpu_eligible(input logic [LVL_W-1:0] req,
                                        input logic [LVL_W-1:0] cur);
    return req > cur;
  endfunction

  function automatic logic [VEC_W-1:0] trap_vector(input logic [TIDX_W-1:0] t);
    return VEC_W'(NUM_SRC) + VEC_W'(t);
  endfunction

  function automatic logic [NUM_SRC-1:0] src_onehot(input logic [IDX_W-1:0] i);
    return {{(NUM_SRC-1){1'b0}}, 1'b1} << i;
  endfunction

  irq_req_latch #(.N(NUM_SRC)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_req_i),
    .clr_i  (ack_clr),
    .pend_o (pend)
  );

  irq_prio_tree #(.N(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend),
    .lvl_i       (lvl_q),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  irq_trap_unit #(.NT(NUM_TRAP), .TIDX_W(TIDX_W)) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_i     (trap_i),
    .clr_we_i   (trap_clr_we_i),
    .clr_mask_i (trap_clr_mask_i),
    .ready_i    (ack_ready_i),
    .reti_i     (reti_i),
    .go_o       (trap_go),
    .idx_o      (trap_idx),
    .busy_o     (trap_busy),
    .in_svc_o   (trap_in_svc),
    .flags_o    (trap_flags_o)
  );

  // a winner is routed by its own bit; only the CPU path sees the level test
  assign win_xfer = xfer_q[win_idx];
  assign irq_go   = ack_ready_i && !trap_busy && win_valid &&
                    (win_xfer || cpu_eligible(win_lvl, cpu_level_o));
  assign cpu_go   = irq_go && !win_xfer;
  assign ack_clr  = irq_go ? src_onehot(win_idx) : '0;
  assign lvl_reti = reti_i && !trap_in_svc;

  irq_level_ctrl #(.LVL_W(LVL_W)) u_level (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_i     (cpu_go),
    .raise_lvl_i (win_lvl),
    .reti_i      (lvl_reti),
    .cpu_level_o (cpu_level_o)
  );

  // ---------------- registered acknowledge ----------------
  ack_kind_e        ack_kind_q;
  logic             ack_valid_q;
  logic [VEC_W-1:0] ack_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_q <= 1'b0;
      ack_kind_q  <= ACK_NONE;
      ack_vec_q   <= '0;
    end else if (trap_go) begin
      ack_valid_q <= 1'b1;
      ack_kind_q  <= ACK_TRAP;
      ack_vec_q   <= trap_vector(trap_idx);
    end else if (irq_go) begin
      ack_valid_q <= 1'b1;
      ack_kind_q  <= win_xfer ? ACK_XFER : ACK_CPU;
      ack_vec_q   <= VEC_W'(win_idx);
    end else begin
      ack_valid_q <= 1'b0;
      ack_kind_q  <= ACK_NONE;
      ack_vec_q   <= '0;
    end
  end

  assign ack_valid_o  = ack_valid_q;
  assign ack_kind_o   = ack_kind_q;
  assign ack_vector_o = ack_vec_q;

  // R10: interrupts and transfers never leave while a trap was pending or active
  p_no_irq_under_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && (ack_kind_o != ACK_TRAP)) |-> !$past(trap_busy));

  // R11: no acknowledge follows a cycle without ready
  p_hold_without_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_ready_i) |-> !ack_valid_o);

  // R5: a CPU interrupt acknowledge comes with a raised level
  p_cpu_ack_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && (ack_kind_o == ACK_CPU)) |-> (cpu_level_o > $past(cpu_level_o)));

  // R4: a transfer acknowledge leaves the level alone unless a return came with it
  p_xfer_keeps_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && (ack_kind_o == ACK_XFER) && !$past(reti_i)) |-> $stable(cpu_level_o));

  // R6: trap vectors sit above the source range, source vectors inside it
  p_vector_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> ((ack_kind_o == ACK_TRAP) == (ack_vector_o >= VEC_W'(NUM_SRC))));

endmodule

// File: tb/irq_trap_arbiter_bench.sv
`timescale 1ns/1ps
module irq_trap_arbiter_bench;

  localparam int NS = 16;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_src = '0;
  logic [3:0]  cfg_lvl = '0;
  logic        cfg_xfer = 1'b0;
  logic [3:0]  trap = '0;
  logic        clr_we = 1'b0;
  logic [3:0]  clr_mask = '0;
  logic        reti = 1'b0;
  logic        ready = 1'b0;

  logic        ack_valid;
  logic [1:0]  ack_kind;
  logic [4:0]  ack_vec;
  logic [3:0]  cpu_level;
  logic [3:0]  trap_flags;

  always #2.5 clk = ~clk;

  irq_trap_arbiter u_irq_trap_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq),
    .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_level_i(cfg_lvl), .cfg_xfer_i(cfg_xfer),
    .trap_i(trap), .trap_clr_we_i(clr_we), .trap_clr_mask_i(clr_mask),
    .reti_i(reti), .ack_ready_i(ready),
    .ack_valid_o(ack_valid), .ack_kind_o(ack_kind), .ack_vector_o(ack_vec),
    .cpu_level_o(cpu_level), .trap_flags_o(trap_flags)
  );

  // ---------------- behavioural reference ----------------
  int m_lvl[NS], m_xfer[NS], m_pend[NS];
  int m_tpend[NT], m_tflag[NT];
  int lvl_stack[$];
  int trap_stack[$];
  logic       e_valid = 1'b0;
  logic [1:0] e_kind = '0;
  logic [4:0] e_vec = '0;
  logic [3:0] e_lvl = '0;
  logic [3:0] e_flags = '0;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  task automatic model_step();
    int cand, best, cur, tbusy, tgo, igo;
    cur = (lvl_stack.size() == 0) ? 0 : lvl_stack[$];
    cand = -1;
    for (int t = 0; t < NT; t++) if (m_tpend[t] != 0 && cand < 0) cand = t;
    tbusy = (cand >= 0 || trap_stack.size() > 0) ? 1 : 0;
    tgo = (ready && cand >= 0 && (trap_stack.size() == 0 || cand < trap_stack[$])) ? 1 : 0;
    best = -1;
    for (int i = 0; i < NS; i++)
      if (m_pend[i] != 0 && m_lvl[i] > 0 && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
    igo = (ready && tbusy == 0 && best >= 0 && (m_xfer[best] != 0 || m_lvl[best] > cur)) ? 1 : 0;

    if (tgo != 0)      begin e_valid = 1'b1; e_kind = 2'd3; e_vec = 5'(NS + cand); end
    else if (igo != 0) begin e_valid = 1'b1; e_kind = (m_xfer[best] != 0) ? 2'd2 : 2'd1; e_vec = 5'(best); end
    else               begin e_valid = 1'b0; e_kind = 2'd0; e_vec = 5'd0; end

    if (reti) begin
      if (trap_stack.size() > 0)     void'(trap_stack.pop_back());
      else if (lvl_stack.size() > 0) void'(lvl_stack.pop_back());
    end
    if (tgo != 0) begin trap_stack.push_back(cand); m_tpend[cand] = 0; end
    if (igo != 0) begin
      m_pend[best] = 0;
      if (m_xfer[best] == 0) lvl_stack.push_back(m_lvl[best]);
    end
    for (int i = 0; i < NS; i++) if (irq[i]) m_pend[i] = 1;
    for (int t = 0; t < NT; t++) begin
      if (clr_we && clr_mask[t]) m_tflag[t] = 0;
      if (trap[t]) begin m_tflag[t] = 1; m_tpend[t] = 1; end
    end
    if (cfg_we) begin m_lvl[cfg_src] = int'(cfg_lvl); m_xfer[cfg_src] = int'(cfg_xfer); end

    e_lvl = (lvl_stack.size() == 0) ? 4'd0 : 4'(lvl_stack[$]);
    for (int t = 0; t < NT; t++) e_flags[t] = (m_tflag[t] != 0);
  endtask

  task automatic compare();
    int bad;
    bad = 0;
    vectors++;
    if (ack_valid !== e_valid) begin bad = 1;
      $display("FAIL %s ack_valid got %0b exp %0b at %0t", cur_req, ack_valid, e_valid, $time); end
    if (ack_kind !== e_kind) begin bad = 1;
      $display("FAIL %s ack_kind got %0d exp %0d at %0t", cur_req, ack_kind, e_kind, $time); end
    if (ack_vec !== e_vec) begin bad = 1;
      $display("FAIL %s/R6 ack_vector got %0d exp %0d at %0t", cur_req, ack_vec, e_vec, $time); end
    if (cpu_level !== e_lvl) begin bad = 1;
      $display("FAIL %s cpu_level got %0d exp %0d at %0t", cur_req, cpu_level, e_lvl, $time); end
    if (trap_flags !== e_flags) begin bad = 1;
      $display("FAIL %s trap_flags got %b exp %b at %0t", cur_req, trap_flags, e_flags, $time); end
    if (bad != 0) miscompares++;
  endtask

  // inputs are set at the falling edge before each call
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
    @(negedge clk);
    irq = '0; trap = '0; cfg_we = 1'b0; clr_we = 1'b0; clr_mask = '0; reti = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic configure(input int s, input int l, input int x);
    cfg_we = 1'b1; cfg_src = 4'(s); cfg_lvl = 4'(l); cfg_xfer = (x != 0);
    tick();
  endtask

  task automatic do_reti();
    reti = 1'b1;
    tick();
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_lvl[i] = 0; m_xfer[i] = 0; m_pend[i] = 0; end
    for (int t = 0; t < NT; t++) begin m_tpend[t] = 0; m_tflag[t] = 0; end
    ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_req = "R1"; compare();          // R1: reset state
    @(negedge clk);

    cur_req = "R12";                     // R12: program levels and routing
    configure(3, 5, 0);
    configure(7, 5, 0);
    configure(9, 9, 1);
    configure(12, 0, 0);
    configure(1, 2, 0);
    configure(14, 13, 0);

    cur_req = "R2";                      // R2: one pulse, one acknowledge
    irq[3] = 1'b1; tick(); idle(3);
    irq[3] = 1'b1; tick(); idle(2);      // level 5 not above 5: waits
    cur_req = "R7";
    do_reti(); idle(3);                  // R7: level drops, pending 3 granted
    do_reti(); idle(1);
    do_reti(); idle(1);                  // R7: return with nothing in service

    cur_req = "R3";                      // R3: equal levels, lower index first
    irq[3] = 1'b1; irq[7] = 1'b1; tick(); idle(3);
    cur_req = "R5";                      // R5: 7 blocked at level 5
    do_reti(); idle(3);
    do_reti(); idle(1);
    cur_req = "R3";
    irq[12] = 1'b1; tick(); idle(3);     // R3: level 0 never wins
    ready = 1'b0; irq[1] = 1'b1; tick();
    irq[14] = 1'b1; tick();
    ready = 1'b1; idle(3);               // R3: newer high request overtakes
    cur_req = "R5";
    do_reti(); idle(3);
    do_reti(); idle(1);

    cur_req = "R4";                      // R4: transfer below CPU level
    irq[14] = 1'b1; tick(); idle(2);
    irq[9] = 1'b1; tick(); idle(3);
    do_reti(); idle(1);

    cur_req = "R12";                     // R12: reroute source 9 to CPU path
    configure(9, 4, 0);
    irq[9] = 1'b1; tick(); idle(3);
    do_reti(); idle(1);

    cur_req = "R8";                      // R8: sticky flags, set wins over clear
    trap[2] = 1'b1; tick(); idle(2);
    trap[2] = 1'b1; clr_we = 1'b1; clr_mask = 4'b0100; tick(); idle(2);
    cur_req = "R9";
    do_reti(); idle(1);
    do_reti(); idle(1);
    cur_req = "R8";
    clr_we = 1'b1; clr_mask = 4'b0100; tick(); idle(1);

    cur_req = "R9";                      // R9/R10: nested traps with waiting irq
    trap[2] = 1'b1; tick(); idle(2);
    cur_req = "R10";
    irq[3] = 1'b1; tick(); idle(2);
    cur_req = "R9";
    trap[1] = 1'b1; tick(); idle(2);
    trap[3] = 1'b1; tick(); idle(2);
    do_reti(); idle(2);
    do_reti(); idle(2);
    do_reti(); idle(2);
    cur_req = "R10";
    idle(2);
    do_reti(); idle(1);
    clr_we = 1'b1; clr_mask = 4'hF; tick();

    cur_req = "R11";                     // R11: ready low holds everything
    ready = 1'b0; irq[7] = 1'b1; trap[0] = 1'b1; tick(); idle(4);
    ready = 1'b1; idle(4);
    do_reti(); idle(2);
    do_reti(); idle(2);

    cur_req = "R3";                      // mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      irq    = 16'($urandom) & 16'($urandom) & 16'($urandom);
      ready  = ($urandom % 100) < 85;
      reti   = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) trap = 4'(1 << ($urandom % NT));
      if (($urandom % 20) == 0) begin clr_we = 1'b1; clr_mask = 4'($urandom); end
      if (($urandom % 10) == 0) begin
        cfg_we = 1'b1; cfg_src = 4'($urandom); cfg_lvl = 4'($urandom); cfg_xfer = $urandom % 3 == 0;
      end
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired at %0t", $time);
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule